// File: doc/BRIEF.md
# Microcode sequencer with residence table

This block is the control unit that steps a reconfigurable execution unit through microprograms. Its control store is split into a fixed region, filled at boot through a write port and holding frequently used microprograms, and a pageable region made of equal slots that are filled from main memory on demand. A start request carries a residence flag and an address. With the flag clear, the address is a control-store location and execution begins there at once. With the flag set, the address is a main-memory address. A small fully associative residence table maps it to a pageable slot. On a miss, the block copies the microprogram into the slot the replacement pointer names, records the mapping and then runs it.

The sequencer keeps a control-store address register and a microinstruction register. Each microinstruction is 64 bits. Bits [63:62] give its kind: 00 issues the word to the execution unit, 01 is a conditional forward skip, 10 is a conditional backward branch, and 11 ends the microprogram. Bits [15:0] hold the branch distance. The condition is the flag that the execution unit returns with its acknowledge of the most recent issued word. A one-cycle done pulse marks the end of each run.

Top module: `ucode_seq`

## Requirements
- R1: After reset, start_ready is 1, and done, exu_valid and mem_req are 0.
- R2: A start with start_pageable=0 runs the microprogram at control-store address start_addr[CS_AW-1:0] and makes no memory read.
- R3: A start with start_pageable=1 whose address is not in the residence table reads main memory at consecutive addresses from start_addr, up to and including the first word of kind 11 (bits [63:62]). Each request holds mem_addr stable until mem_ack. The block then runs the copied microprogram.
- R4: A start with start_pageable=1 whose address was loaded earlier and not yet replaced makes no memory read and runs the same microinstruction sequence.
- R5: The table has NSLOT entries. Fills take entries 0, 1, ..., NSLOT-1, 0, ... in turn, and each fill replaces the mapping held by that entry.
- R6: A word of kind 01 with distance d at address a continues at a+1+d when the condition flag is 1, and at a+1 otherwise. The flag is the exu_cond value returned with the latest exu_ack, and it is cleared to 0 when a start is accepted.
- R7: A word of kind 10 with distance d at address a continues at a-d when the condition flag is 1, and at a+1 otherwise.
- R8: On a word of kind 11, done is 1 for exactly one cycle and start_ready returns to 1.
- R9: start_valid while start_ready is 0 has no effect: no memory read, no extra issue, no extra done.
- R10: Every word of kind 00 is presented in program order on exu_word with exu_valid. The word stays stable until exu_ack, and only one word is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_valid | input | 1 | Start request |
| start_pageable | input | 1 | 1: start_addr is a memory address; 0: control-store address |
| start_addr | input | MEM_AW (20) | Microprogram start address |
| start_ready | output | 1 | Sequencer idle, start accepted |
| done | output | 1 | One-cycle pulse at end of microprogram |
| boot_we | input | 1 | Write enable for the control store while idle |
| boot_addr | input | CS_AW (10) | Control-store write address |
| boot_data | input | 64 | Control-store write data |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | MEM_AW (20) | Memory read address |
| mem_ack | input | 1 | Memory read data valid |
| mem_rdata | input | 64 | Memory read data |
| exu_valid | output | 1 | Microinstruction offered to the execution unit |
| exu_word | output | 64 | Microinstruction to execute |
| exu_ack | input | 1 | Execution unit accepted and finished the word |
| exu_cond | input | 1 | Condition feedback, valid with exu_ack |

## Verification
The hardest case to reach is replacement: a pageable microprogram must be evicted and then fetched again while its neighbours still hit. The stimulus fills every table entry and then adds one more program. It follows with starts whose expected hit or miss comes from a bench model of the round-robin pointer. A loop built from a backward branch is driven by a condition pattern that runs out after a set number of passes. A second start is offered while a run is in progress. Random programs with forward skips are started in random order from both regions, with random delays on both handshakes.

// File: rtl/ucode_seq_pkg.sv
package ucode_seq_pkg;
  localparam int UW    = 64;
  localparam int OFF_W = 16;

  typedef enum logic [1:0] {
    K_EXEC = 2'b00,
    K_SKIP = 2'b01,
    K_BACK = 2'b10,
    K_END  = 2'b11
  } ukind_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_FILL,
    S_FETCH,
    S_LOAD,
    S_DECODE,
    S_EWAIT
  } seq_state_e;

  function automatic ukind_e kind_of(input logic [UW-1:0] w);
    return ukind_e'(w[UW-1:UW-2]);
  endfunction
endpackage

// File: rtl/ucode_store.sv
module ucode_store #(
  parameter int AW = 10,
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [0:DEPTH-1];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/ucode_restab.sv
module ucode_restab #(
  parameter int NSLOT = 4,
  parameter int TAG_W = 20,
  parameter int IDX_W = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             lk_hit,
  output logic [IDX_W-1:0] lk_idx,
  output logic [IDX_W-1:0] victim,
  input  logic             upd_en,
  input  logic [TAG_W-1:0] upd_tag
);
  logic [TAG_W-1:0] tag_q [NSLOT];
  logic [NSLOT-1:0] val_q;
  logic [NSLOT-1:0] hit_vec;
  logic [IDX_W-1:0] rr_q;

  generate
    for (genvar g = 0; g < NSLOT; g++) begin : g_cmp
      assign hit_vec[g] = val_q[g] && (tag_q[g] == lk_tag);
    end
  endgenerate

  always_comb begin
    lk_idx = '0;
    for (int i = 0; i < NSLOT; i++) begin
      if (hit_vec[i]) lk_idx = IDX_W'(i);
    end
  end

  assign lk_hit = |hit_vec;
  assign victim = rr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      val_q <= '0;
      rr_q  <= '0;
      for (int i = 0; i < NSLOT; i++) tag_q[i] <= '0;
    end else if (upd_en) begin
      for (int i = 0; i < NSLOT; i++) begin
        if (rr_q == IDX_W'(i)) begin
          val_q[i] <= 1'b1;
          tag_q[i] <= upd_tag;
        end
      end
      rr_q <= (rr_q == IDX_W'(NSLOT - 1)) ? '0 : rr_q + IDX_W'(1);
    end
  end

  // R4: one address never maps to two slots
  p_hit_onehot_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_vec));

  // R5: pointer advances exactly once per recorded fill
  p_rr_step_r5: assert property (@(posedge clk) disable iff (rst)
    !upd_en |=> $stable(rr_q));
endmodule

// File: rtl/ucode_fsm.sv
module ucode_fsm
  import ucode_seq_pkg::*;
#(
  parameter int CS_AW       = 10,
  parameter int MEM_AW      = 20,
  parameter int FIXED_WORDS = 512,
  parameter int NSLOT       = 4,
  parameter int SLOT_AW     = 7,
  parameter int IDX_W       = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_valid,
  input  logic              start_pageable,
  input  logic [MEM_AW-1:0] start_addr,
  output logic              start_ready,
  output logic              done,
  output logic [MEM_AW-1:0] lk_tag,
  input  logic              lk_hit,
  input  logic [IDX_W-1:0]  lk_idx,
  input  logic [IDX_W-1:0]  victim,
  output logic              upd_en,
  output logic [MEM_AW-1:0] upd_tag,
  output logic              cs_we,
  output logic [CS_AW-1:0]  cs_waddr,
  output logic [UW-1:0]     cs_wdata,
  output logic [CS_AW-1:0]  cs_raddr,
  input  logic [UW-1:0]     cs_rdata,
  output logic              mem_req,
  output logic [MEM_AW-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic [UW-1:0]     mem_rdata,
  output logic              exu_valid,
  output logic [UW-1:0]     exu_word,
  input  logic              exu_ack,
  input  logic              exu_cond
);
  localparam logic [CS_AW-1:0] ONE = CS_AW'(1);

  seq_state_e          state_q;
  logic [CS_AW-1:0]    csar_q;
  logic [UW-1:0]       mir_q;
  logic                cond_q;
  logic [SLOT_AW-1:0]  fill_cnt_q;
  logic [IDX_W-1:0]    fill_slot_q;
  logic [MEM_AW-1:0]   fill_tag_q;
  logic                mem_req_q;
  logic [MEM_AW-1:0]   mem_addr_q;
  logic                exu_valid_q;
  logic [UW-1:0]       exu_word_q;
  logic                done_q;
  logic                fill_last;
  logic [CS_AW-1:0]    off_v;
  logic                accept;

  function automatic logic [CS_AW-1:0] base_of(input logic [IDX_W-1:0] s);
    return CS_AW'(FIXED_WORDS) + (CS_AW'(s) << SLOT_AW);
  endfunction

  assign accept      = start_valid && (state_q == S_IDLE);
  assign start_ready = (state_q == S_IDLE);
  assign done        = done_q;
  assign lk_tag      = start_addr;
  assign mem_req     = mem_req_q;
  assign mem_addr    = mem_addr_q;
  assign exu_valid   = exu_valid_q;
  assign exu_word    = exu_word_q;
  assign cs_raddr    = csar_q;
  assign off_v       = CS_AW'(mir_q[OFF_W-1:0]);

  assign fill_last = (kind_of(mem_rdata) == K_END) ||
                     (fill_cnt_q == {SLOT_AW{1'b1}});
  assign cs_we     = (state_q == S_FILL) && mem_ack;
  assign cs_waddr  = base_of(fill_slot_q) + CS_AW'(fill_cnt_q);
  assign cs_wdata  = mem_rdata;
  assign upd_en    = cs_we && fill_last;
  assign upd_tag   = fill_tag_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= S_IDLE;
      csar_q      <= '0;
      mir_q       <= '0;
      cond_q      <= 1'b0;
      fill_cnt_q  <= '0;
      fill_slot_q <= '0;
      fill_tag_q  <= '0;
      mem_req_q   <= 1'b0;
      mem_addr_q  <= '0;
      exu_valid_q <= 1'b0;
      exu_word_q  <= '0;
      done_q      <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        S_IDLE: begin
          if (start_valid) begin
            cond_q <= 1'b0;
            if (!start_pageable) begin
              csar_q  <= start_addr[CS_AW-1:0];
              state_q <= S_FETCH;
            end else if (lk_hit) begin
              csar_q  <= base_of(lk_idx);
              state_q <= S_FETCH;
            end else begin
              fill_slot_q <= victim;
              fill_tag_q  <= start_addr;
              fill_cnt_q  <= '0;
              mem_addr_q  <= start_addr;
              mem_req_q   <= 1'b1;
              state_q     <= S_FILL;
            end
          end
        end
        S_FILL: begin
          if (mem_ack) begin
            if (fill_last) begin
              mem_req_q <= 1'b0;
              csar_q    <= base_of(fill_slot_q);
              state_q   <= S_FETCH;
            end else begin
              fill_cnt_q <= fill_cnt_q + SLOT_AW'(1);
              mem_addr_q <= mem_addr_q + MEM_AW'(1);
            end
          end
        end
        S_FETCH: state_q <= S_LOAD;
        S_LOAD: begin
          mir_q   <= cs_rdata;
          state_q <= S_DECODE;
        end
        S_DECODE: begin
          case (kind_of(mir_q))
            K_EXEC: begin
              exu_valid_q <= 1'b1;
              exu_word_q  <= mir_q;
              state_q     <= S_EWAIT;
            end
            K_SKIP: begin
              csar_q  <= cond_q ? (csar_q + off_v + ONE) : (csar_q + ONE);
              state_q <= S_FETCH;
            end
            K_BACK: begin
              csar_q  <= cond_q ? (csar_q - off_v) : (csar_q + ONE);
              state_q <= S_FETCH;
            end
            default: begin
              done_q  <= 1'b1;
              state_q <= S_IDLE;
            end
          endcase
        end
        S_EWAIT: begin
          if (exu_ack) begin
            exu_valid_q <= 1'b0;
            cond_q      <= exu_cond;
            csar_q      <= csar_q + ONE;
            state_q     <= S_FETCH;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // R8: end marker gives a single-cycle pulse
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);

  // R10: offered word held until accepted
  p_exu_hold_r10: assert property (@(posedge clk) disable iff (rst)
    exu_valid_q && !exu_ack |=> exu_valid_q && $stable(exu_word_q));

  // R3: memory request held until acknowledged
  p_mem_hold_r3: assert property (@(posedge clk) disable iff (rst)
    mem_req_q && !mem_ack |=> mem_req_q && $stable(mem_addr_q));

  // R3: fills land only in the pageable region
  p_fill_region_r3: assert property (@(posedge clk) disable iff (rst)
    cs_we |-> (cs_waddr >= CS_AW'(FIXED_WORDS)));

  // R2: resident start never touches memory
  p_resident_nomem_r2: assert property (@(posedge clk) disable iff (rst)
    accept && !start_pageable |=> !mem_req_q);

  // R4: table hit never touches memory
  p_hit_nomem_r4: assert property (@(posedge clk) disable iff (rst)
    accept && start_pageable && lk_hit |=> !mem_req_q);

  // R5: replacement pointer does not move while a fill is in progress
  p_fill_slot_r5: assert property (@(posedge clk) disable iff (rst)
    mem_req_q |-> (victim == fill_slot_q));

  // R9: no request while busy changes the state register out of order
  p_busy_ignore_r9: assert property (@(posedge clk) disable iff (rst)
    start_valid && (state_q == S_EWAIT) && !exu_ack |=> state_q == S_EWAIT);
endmodule

// File: rtl/ucode_seq.sv
module ucode_seq
  import ucode_seq_pkg::*;
#(
  parameter int CS_AW       = 10,
  parameter int MEM_AW      = 20,
  parameter int FIXED_WORDS = 512,
  parameter int NSLOT       = 4,
  parameter int SLOT_AW     = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_valid,
  input  logic              start_pageable,
  input  logic [MEM_AW-1:0] start_addr,
  output logic              start_ready,
  output logic              done,
  input  logic              boot_we,
  input  logic [CS_AW-1:0]  boot_addr,
  input  logic [63:0]       boot_data,
  output logic              mem_req,
  output logic [MEM_AW-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic [63:0]       mem_rdata,
  output logic              exu_valid,
  output logic [63:0]       exu_word,
  input  logic              exu_ack,
  input  logic              exu_cond
);
  localparam int IDX_W = (NSLOT > 1) ? $clog2(NSLOT) : 1;

  logic [MEM_AW-1:0] lk_tag;
  logic              lk_hit;
  logic [IDX_W-1:0]  lk_idx;
  logic [IDX_W-1:0]  victim;
  logic              upd_en;
  logic [MEM_AW-1:0] upd_tag;
  logic              f_we;
  logic [CS_AW-1:0]  f_waddr;
  logic [UW-1:0]     f_wdata;
  logic [CS_AW-1:0]  cs_raddr;
  logic [UW-1:0]     cs_rdata;
  logic              st_we;
  logic [CS_AW-1:0]  st_waddr;
  logic [UW-1:0]     st_wdata;

  assign st_we    = f_we || (boot_we && start_ready);
  assign st_waddr = f_we ? f_waddr : boot_addr;
  assign st_wdata = f_we ? f_wdata : boot_data;

  ucode_store #(.AW(CS_AW), .DW(UW)) store_i (
    .clk   (clk),
    .we    (st_we),
    .waddr (st_waddr),
    .wdata (st_wdata),
    .raddr (cs_raddr),
    .rdata (cs_rdata)
  );

  ucode_restab #(.NSLOT(NSLOT), .TAG_W(MEM_AW), .IDX_W(IDX_W)) restab_i (
    .clk     (clk),
    .rst     (rst),
    .lk_tag  (lk_tag),
    .lk_hit  (lk_hit),
    .lk_idx  (lk_idx),
    .victim  (victim),
    .upd_en  (upd_en),
    .upd_tag (upd_tag)
  );

  ucode_fsm #(
    .CS_AW(CS_AW), .MEM_AW(MEM_AW), .FIXED_WORDS(FIXED_WORDS),
    .NSLOT(NSLOT), .SLOT_AW(SLOT_AW), .IDX_W(IDX_W)
  ) fsm_i (
    .clk            (clk),
    .rst            (rst),
    .start_valid    (start_valid),
    .start_pageable (start_pageable),
    .start_addr     (start_addr),
    .start_ready    (start_ready),
    .done           (done),
    .lk_tag         (lk_tag),
    .lk_hit         (lk_hit),
    .lk_idx         (lk_idx),
    .victim         (victim),
    .upd_en         (upd_en),
    .upd_tag        (upd_tag),
    .cs_we          (f_we),
    .cs_waddr       (f_waddr),
    .cs_wdata       (f_wdata),
    .cs_raddr       (cs_raddr),
    .cs_rdata       (cs_rdata),
    .mem_req        (mem_req),
    .mem_addr       (mem_addr),
    .mem_ack        (mem_ack),
    .mem_rdata      (mem_rdata),
    .exu_valid      (exu_valid),
    .exu_word       (exu_word),
    .exu_ack        (exu_ack),
    .exu_cond       (exu_cond)
  );

  // R1: idle outputs right after reset
  p_reset_idle_r1: assert property (@(posedge clk)
    $past(rst) |-> start_ready && !done && !mem_req && !exu_valid);
endmodule

// File: tb/ucode_seq_tb_top.sv
`timescale 1ns/1ps
module ucode_seq_tb_top;
  localparam int CS_AW = 10, MEM_AW = 20, FIXED = 512, NSLOT = 4, SLOT_AW = 7;
  localparam int NPROG = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic              start_valid = 0, start_pageable = 0;
  logic [MEM_AW-1:0] start_addr = '0;
  logic              start_ready, done;
  logic              boot_we = 0;
  logic [CS_AW-1:0]  boot_addr = '0;
  logic [63:0]       boot_data = '0;
  logic              mem_req;
  logic [MEM_AW-1:0] mem_addr;
  logic              mem_ack = 0;
  logic [63:0]       mem_rdata = '0;
  logic              exu_valid;
  logic [63:0]       exu_word;
  logic              exu_ack = 0, exu_cond = 0;

  ucode_seq #(.CS_AW(CS_AW), .MEM_AW(MEM_AW), .FIXED_WORDS(FIXED),
              .NSLOT(NSLOT), .SLOT_AW(SLOT_AW)) dut_i (
    .clk(clk), .rst(rst), .start_valid(start_valid), .start_pageable(start_pageable),
    .start_addr(start_addr), .start_ready(start_ready), .done(done),
    .boot_we(boot_we), .boot_addr(boot_addr), .boot_data(boot_data),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .exu_valid(exu_valid), .exu_word(exu_word), .exu_ack(exu_ack), .exu_cond(exu_cond)
  );

  logic [63:0] mem_img [0:4095];
  logic [63:0] prog_w  [0:NPROG-1][0:15];
  int          prog_len [NPROG];
  bit          is_pg    [NPROG];
  int          paddr    [NPROG];
  logic [63:0] expw [0:255];
  logic [63:0] gotw [0:255];
  int exp_n, gn, mrd, mfirst, mprev, rsp_ml, loopn;
  bit mseq_ok;
  int tab_tag [NSLOT];
  bit tab_v   [NSLOT];
  int tab_rr;
  int total = 0, bad = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // execution unit responder
  initial begin
    int w;
    w = 0;
    forever begin
      @(negedge clk);
      if (exu_ack) exu_ack = 0;
      else if (exu_valid) begin
        if (w > 0) w--;
        else begin
          exu_ack = 1;
          if (gn < 256) gotw[gn] = exu_word;
          gn++;
          if (exu_word[17]) begin
            exu_cond = (rsp_ml > 0);
            if (rsp_ml > 0) rsp_ml--;
          end else exu_cond = exu_word[16];
          w = $urandom % 3;
        end
      end
    end
  end

  // memory responder
  initial begin
    int w;
    w = 0;
    forever begin
      @(negedge clk);
      if (mem_ack) mem_ack = 0;
      else if (mem_req) begin
        if (w > 0) w--;
        else begin
          mem_ack = 1;
          mem_rdata = mem_img[mem_addr[11:0]];
          if (mrd == 0) mfirst = int'(mem_addr);
          else if (int'(mem_addr) != mprev + 1) mseq_ok = 0;
          mprev = int'(mem_addr);
          mrd++;
          w = $urandom % 3;
        end
      end
    end
  end

  function automatic logic [63:0] mk_exec(input bit c, input bit lp);
    logic [63:0] w;
    w = {$urandom, $urandom};
    w[63:62] = 2'b00;
    w[17] = lp;
    w[16] = c;
    return w;
  endfunction

  function automatic logic [63:0] mk_ctl(input logic [1:0] k, input int off);
    logic [63:0] w;
    w = {$urandom, $urandom};
    w[63:62] = k;
    w[15:0] = 16'(off);
    return w;
  endfunction

  task automatic install(input int p);
    for (int i = 0; i < prog_len[p]; i++) begin
      if (is_pg[p]) mem_img[(paddr[p] + i) % 4096] = prog_w[p][i];
      else begin
        @(negedge clk);
        boot_we = 1;
        boot_addr = CS_AW'(paddr[p] + i);
        boot_data = prog_w[p][i];
      end
    end
    @(negedge clk);
    boot_we = 0;
  endtask

  task automatic mk_rand(input int p, input int len);
    prog_len[p] = len;
    for (int i = 0; i < len - 1; i++) begin
      if (i < len - 2 && ($urandom % 4) == 0)
        prog_w[p][i] = mk_ctl(2'b01, int'($urandom % (len - 1 - i)));
      else
        prog_w[p][i] = mk_exec(1'($urandom % 2), 1'b0);
    end
    prog_w[p][len-1] = mk_ctl(2'b11, 0);
  endtask

  function automatic int tab_lookup(input int a);
    for (int i = 0; i < NSLOT; i++) if (tab_v[i] && tab_tag[i] == a) return i;
    return -1;
  endfunction

  task automatic run(input int p, input string req, input bit inject);
    int cyc, er, pc, ml, fb;
    bit cnd;
    logic [63:0] w;
    exp_n = 0; pc = 0; ml = loopn; cnd = 0;
    for (int s = 0; s < 400; s++) begin
      w = prog_w[p][pc];
      if (w[63:62] == 2'b11) break;
      case (w[63:62])
        2'b00: begin
          expw[exp_n] = w; exp_n++;
          if (w[17]) begin cnd = (ml > 0); if (ml > 0) ml--; end
          else cnd = w[16];
          pc++;
        end
        2'b01:   pc = cnd ? pc + 1 + int'(w[15:0]) : pc + 1;
        default: pc = cnd ? pc - int'(w[15:0]) : pc + 1;
      endcase
    end
    er = 0;
    if (is_pg[p] && tab_lookup(paddr[p]) < 0) begin
      er = prog_len[p];
      tab_tag[tab_rr] = paddr[p]; tab_v[tab_rr] = 1;
      tab_rr = (tab_rr + 1) % NSLOT;
    end
    gn = 0; mrd = 0; mseq_ok = 1; rsp_ml = loopn;
    @(negedge clk);
    start_valid = 1; start_pageable = is_pg[p]; start_addr = MEM_AW'(paddr[p]);
    @(negedge clk);
    start_valid = 0;
    cyc = 0;
    while (!done && cyc < 4000) begin
      @(negedge clk);
      cyc++;
      if (inject && cyc == 3) begin
        start_valid = 1; start_pageable = 1; start_addr = MEM_AW'(paddr[11]);
      end
      if (inject && cyc == 4) start_valid = 0;
    end
    chk(done, "R8", {req, " done pulse seen"}, 64'(done), 64'd1);
    @(negedge clk);
    chk(!done && start_ready, "R8", "done one cycle, ready back",
        64'({done, start_ready}), 64'b01);
    fb = -1;
    for (int i = 0; i < exp_n; i++) if (fb < 0 && (i >= gn || gotw[i] != expw[i])) fb = i;
    chk(gn == exp_n, "R10", {req, " issue count"}, 64'(gn), 64'(exp_n));
    if (fb >= 0) chk(0, "R10", {req, " issued word"}, gotw[fb], expw[fb]);
    else chk(1, "R10", {req, " issued words"}, 0, 0);
    chk(mrd == er, req, "memory reads", 64'(mrd), 64'(er));
    if (er > 0)
      chk(mfirst == paddr[p] && mseq_ok, "R3", "fill address sequence",
          64'(mfirst), 64'(paddr[p]));
    if (inject) begin
      repeat (10) @(negedge clk);
      chk(mrd == er && gn == exp_n && start_ready && !exu_valid, "R9",
          "start while busy ignored", 64'(mrd), 64'(er));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20041));
    for (int i = 0; i < 4096; i++) mem_img[i] = mk_ctl(2'b11, 0);
    for (int i = 0; i < NSLOT; i++) begin tab_v[i] = 0; tab_tag[i] = 0; end
    tab_rr = 0; loopn = 0; gn = 0; mrd = 0; mfirst = 0; mprev = 0; rsp_ml = 0; mseq_ok = 1;
    // pageable pool 0..5, resident pool 6..8
    for (int k = 0; k < 6; k++) begin
      is_pg[k] = 1; paddr[k] = 256 * (k + 1); mk_rand(k, 3 + int'($urandom % 10));
    end
    for (int k = 0; k < 3; k++) begin
      is_pg[6+k] = 0; paddr[6+k] = 16 + 32 * k; mk_rand(6 + k, 3 + int'($urandom % 10));
    end
    // directed skip program, resident
    is_pg[9] = 0; paddr[9] = 300; prog_len[9] = 9;
    prog_w[9][0] = mk_ctl(2'b01, 3);
    prog_w[9][1] = mk_exec(1, 0);
    prog_w[9][2] = mk_ctl(2'b01, 2);
    prog_w[9][3] = mk_exec(0, 0);
    prog_w[9][4] = mk_exec(0, 0);
    prog_w[9][5] = mk_exec(0, 0);
    prog_w[9][6] = mk_ctl(2'b01, 1);
    prog_w[9][7] = mk_exec(1, 0);
    prog_w[9][8] = mk_ctl(2'b11, 0);
    // directed backward loop, pageable
    is_pg[10] = 1; paddr[10] = 2304; prog_len[10] = 4;
    prog_w[10][0] = mk_exec(0, 0);
    prog_w[10][1] = mk_exec(0, 1);
    prog_w[10][2] = mk_ctl(2'b10, 1);
    prog_w[10][3] = mk_ctl(2'b11, 0);
    // never started on purpose
    is_pg[11] = 1; paddr[11] = 3072; prog_len[11] = 2;
    prog_w[11][0] = mk_exec(0, 0);
    prog_w[11][1] = mk_ctl(2'b11, 0);
    for (int p = 0; p < NPROG; p++) if (is_pg[p]) install(p);

    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(start_ready && !done && !exu_valid && !mem_req, "R1", "reset state",
        64'({start_ready, done, exu_valid, mem_req}), 64'b1000);
    for (int p = 6; p < 10; p++) install(p);

    run(6, "R2", 0);
    run(9, "R6", 0);
    loopn = 3;
    run(10, "R7 R3", 0);
    run(10, "R7 R4", 0);
    loopn = 0;
    run(0, "R3", 0);
    run(1, "R3", 0);
    run(2, "R3", 0);
    run(0, "R4", 0);
    run(3, "R5 evict", 0);
    run(1, "R5 keep", 0);
    loopn = 3;
    run(10, "R5 reload", 0);
    loopn = 0;
    run(0, "R5 reload", 0);
    run(7, "R9 R2", 1);
    for (int i = 0; i < 40; i++) run(int'($urandom % 9), "R2 R3 R4 R5", 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule